// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead-Time

This block is the synchronous control for the four gate enables of a full H-bridge. The bridge is split into two half-bridge legs, A and B, each with its own high-side and low-side logic request. The legs run independently but share a stop input (`dis`), a supply-fault flag (`uv`) and two dead-time settings given in clock cycles. Per leg, the block resolves conflicting requests in favour of the low-side switch. It delays every turn-on until the opposite switch of the same leg has been off for a programmed time. Every turn-off takes effect at the next clock edge.

Holding a leg's high-side request at 1 turns it into a single-input leg: the low-side request alone then selects which of the two switches conducts, and the dead time is inserted automatically in both directions. When `dis` or `uv` rises, all four enables drop in the same cycle. When both are low again, a restart sequence runs. First, both low-side enables are forced on for a fixed number of cycles so that the high-side supplies can recharge. After that, low-side enables follow their requests. High-side enables stay blocked until a longer fixed delay, counted from the release, has passed. Reset leaves the block stopped, and the restart sequence runs on the first release.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: While `dis` is 1, all four gate outputs are 0 in the same cycle, combinationally, whatever the other inputs are.
- R2: While `uv` is 1, all four gate outputs are 0, exactly as for `dis`.
- R3: In a leg whose high-side and low-side requests are both 1, the high-side output stays 0 and the low-side output may turn on.
- R4: With a leg's high-side request held at 1, toggling the low-side request alternates that leg's two outputs, with neither on at the same time.
- R5: A high-side output turns on at the edge at which its effective request (high request 1, low request 0, upper stage enabled) has been seen for `hi_dly`+1 consecutive edges with the leg's low-side output already 0. A low-side output turns off at the first edge after its request drops.
- R6: A low-side output turns on at the edge at which its request has been seen for `lo_dly`+1 consecutive edges with the leg's high-side output already 0. A high-side output turns off at the first edge after its effective request drops.
- R7: A delay setting of 0 still leaves exactly one cycle in which both outputs of a leg are 0 between one switch turning off and the other turning on.
- R8: If an effective request drops before its turn-on delay expires, the output stays 0, and a later request waits the full delay again.
- R9: Legs A and B do not affect each other's outputs. They use the same `hi_dly` and `lo_dly` values.
- R10: From the first edge at which neither `dis` nor `uv` is 1 after a stop, both low-side outputs are 1 for REFRESH_W cycles (default 16) whatever their requests, and both high-side outputs are 0.
- R11: After the low-side pulse, low-side outputs follow their requests. High-side outputs stay 0 until UPPER_DLY cycles (default 24) after that first edge, and only then start their own turn-on delay.
- R12: While reset (`rst_n` = 0) is applied, all outputs are 0. The block leaves reset stopped, and R10 and R11 apply to the first release.
- R13: The high-side and low-side outputs of one leg are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dis | input | 1 | Stop: forces all outputs low |
| uv | input | 1 | Supply-fault flag, same effect as `dis` |
| hi_dly | input | 8 | High-side turn-on dead time, in cycles |
| lo_dly | input | 8 | Low-side turn-on dead time, in cycles |
| a_hi_req | input | 1 | Leg A high-side request |
| a_lo_req | input | 1 | Leg A low-side request |
| b_hi_req | input | 1 | Leg B high-side request |
| b_lo_req | input | 1 | Leg B low-side request |
| a_hi_gate | output | 1 | Leg A high-side gate enable |
| a_lo_gate | output | 1 | Leg A low-side gate enable |
| b_hi_gate | output | 1 | Leg B high-side gate enable |
| b_lo_gate | output | 1 | Leg B low-side gate enable |

## Verification
A wrong dead-time counter shows at the ports within one transition. An output rises one or more cycles early or late against the count derived from `hi_dly`/`lo_dly`, or it rises after a cancelled request. A wrong restart state shows in the first cycles after a release. The low-side pulse is shorter or longer than REFRESH_W, or a high-side output appears before UPPER_DLY. The bench predicts every output on every cycle, so each of these faults shows up as a miscompare in the cycle where it occurs.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  typedef enum logic [1:0] {
    SEQ_HALT    = 2'd0,
    SEQ_REFRESH = 2'd1,
    SEQ_LOWER   = 2'd2,
    SEQ_RUN     = 2'd3
  } seq_state_e;

  localparam int unsigned NUM_LEGS = 2;
endpackage

// File: rtl/hbg_seq.sv
module hbg_seq
  import hbg_pkg::*;
#(
  parameter int unsigned REFRESH_W = 16,
  parameter int unsigned UPPER_DLY = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  output logic active,
  output logic refresh,
  output logic upper_en
);
  localparam int unsigned CW = (UPPER_DLY < 2) ? 1 : $clog2(UPPER_DLY + 1);

  seq_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      SEQ_HALT: begin
        st_d  = SEQ_REFRESH;
        cnt_d = '0;
      end
      SEQ_REFRESH: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(REFRESH_W - 1)) st_d = SEQ_LOWER;
      end
      SEQ_LOWER: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(UPPER_DLY - 1)) st_d = SEQ_RUN;
      end
      default: st_d = SEQ_RUN;
    endcase
    if (halt) begin
      st_d  = SEQ_HALT;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_HALT;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign active   = (st_q != SEQ_HALT);
  assign refresh  = (st_q == SEQ_REFRESH);
  assign upper_en = (st_q == SEQ_RUN);

  // R10: the forced low-side pulse only ever starts out of the stopped state
  a_r10_refresh_from_halt: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh) |-> $past(st_q == SEQ_HALT));

  // R10: a stop request ends the sequence at the next edge
  a_r10_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !active);
endmodule

// File: rtl/hbg_dly_gate.sv
module hbg_dly_gate #(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             want,
  input  logic             other_on,
  input  logic [DLY_W-1:0] dly,
  output logic             gate
);
  logic             gate_q, gate_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;

  always_comb begin
    gate_d = gate_q;
    cnt_d  = cnt_q;
    if (!want) begin
      gate_d = 1'b0;
      cnt_d  = '0;
    end else if (!gate_q) begin
      if (other_on)          cnt_d  = '0;
      else if (cnt_q >= dly) gate_d = 1'b1;
      else                   cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      gate_q <= gate_d;
      cnt_q  <= cnt_d;
    end
  end

  assign gate = gate_q;

  // R8: a dropped request clears the output at the next edge
  a_r8_cancel_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !want |=> !gate_q);

  // R5 and R6: turn-on only after the opposite switch was seen off
  a_r5_r6_wait_opposite: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> $past(!other_on));
endmodule

// File: rtl/hbg_leg.sv
module hbg_leg #(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             upper_en,
  input  logic             refresh,
  input  logic             hi_req,
  input  logic             lo_req,
  input  logic [DLY_W-1:0] hi_dly,
  input  logic [DLY_W-1:0] lo_dly,
  output logic             hi_on,
  output logic             lo_on
);
  logic hi_want, lo_want;
  logic hi_g, lo_g;

  // low-side request wins inside the leg
  assign hi_want = en & upper_en & hi_req & ~lo_req;
  assign lo_want = en & lo_req;

  hbg_dly_gate #(.DLY_W(DLY_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .want(hi_want), .other_on(lo_on),
    .dly(hi_dly), .gate(hi_g)
  );

  hbg_dly_gate #(.DLY_W(DLY_W)) u_lo (
    .clk(clk), .rst_n(rst_n), .want(lo_want), .other_on(hi_g),
    .dly(lo_dly), .gate(lo_g)
  );

  assign hi_on = hi_g & upper_en;
  assign lo_on = lo_g | refresh;

  // R13: never both switches of one leg
  a_r13_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_on && lo_on));

  // R3: a low-side request keeps the high side off from the next edge
  a_r3_low_wins: assert property (@(posedge clk) disable iff (!rst_n)
    lo_req |=> !hi_g);
endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
  import hbg_pkg::*;
#(
  parameter int unsigned DLY_W     = 8,
  parameter int unsigned REFRESH_W = 16,
  parameter int unsigned UPPER_DLY = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dis,
  input  logic             uv,
  input  logic [DLY_W-1:0] hi_dly,
  input  logic [DLY_W-1:0] lo_dly,
  input  logic             a_hi_req,
  input  logic             a_lo_req,
  input  logic             b_hi_req,
  input  logic             b_lo_req,
  output logic             a_hi_gate,
  output logic             a_lo_gate,
  output logic             b_hi_gate,
  output logic             b_lo_gate
);
  logic halt, active, refresh, upper_en, leg_en;
  logic [NUM_LEGS-1:0] hi_req_v, lo_req_v, hi_on_v, lo_on_v;

  assign halt     = dis | uv;
  assign leg_en   = active & ~halt;
  assign hi_req_v = {b_hi_req, a_hi_req};
  assign lo_req_v = {b_lo_req, a_lo_req};

  hbg_seq #(.REFRESH_W(REFRESH_W), .UPPER_DLY(UPPER_DLY)) u_seq (
    .clk(clk), .rst_n(rst_n), .halt(halt),
    .active(active), .refresh(refresh), .upper_en(upper_en)
  );

  for (genvar i = 0; i < NUM_LEGS; i++) begin : g_leg
    hbg_leg #(.DLY_W(DLY_W)) u_leg (
      .clk(clk), .rst_n(rst_n), .en(leg_en), .upper_en(upper_en),
      .refresh(refresh), .hi_req(hi_req_v[i]), .lo_req(lo_req_v[i]),
      .hi_dly(hi_dly), .lo_dly(lo_dly),
      .hi_on(hi_on_v[i]), .lo_on(lo_on_v[i])
    );
  end

  assign a_hi_gate = hi_on_v[0] & ~halt;
  assign a_lo_gate = lo_on_v[0] & ~halt;
  assign b_hi_gate = hi_on_v[1] & ~halt;
  assign b_lo_gate = lo_on_v[1] & ~halt;

  // checker-side count of edges since the last stop, saturating
  localparam int unsigned RLW = $clog2(UPPER_DLY + 2);
  logic [RLW-1:0] run_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                run_len_q <= '0;
    else if (halt)                             run_len_q <= '0;
    else if (run_len_q != RLW'(UPPER_DLY + 1)) run_len_q <= run_len_q + 1'b1;
  end

  // R1 and R2: stop or fault clears every output in the same cycle
  a_r1_r2_halt_all_low: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !(a_hi_gate || a_lo_gate || b_hi_gate || b_lo_gate));

  // R11: the upper stage opens only after the full delay since release
  a_r11_upper_late: assert property (@(posedge clk) disable iff (!rst_n)
    upper_en |-> (run_len_q == RLW'(UPPER_DLY + 1)));

  // R10: while the pulse runs, both low sides are on and both high sides off
  a_r10_pulse_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && !halt) |-> (a_lo_gate && b_lo_gate && !a_hi_gate && !b_hi_gate));
endmodule

// File: tb/hbridge_gate_ctrl_bench.sv
module hbridge_gate_ctrl_bench;
  localparam int RW = 16;
  localparam int UP = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dis = 1'b1, uv = 1'b0;
  logic [7:0] hi_dly = 8'd0, lo_dly = 8'd0;
  logic a_hr = 1'b0, a_lr = 1'b0, b_hr = 1'b0, b_lr = 1'b0;
  logic a_hg, a_lg, b_hg, b_lg;

  always #5 clk = ~clk;

  hbridge_gate_ctrl u_hbridge_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .dis(dis), .uv(uv),
    .hi_dly(hi_dly), .lo_dly(lo_dly),
    .a_hi_req(a_hr), .a_lo_req(a_lr), .b_hi_req(b_hr), .b_lo_req(b_lr),
    .a_hi_gate(a_hg), .a_lo_gate(a_lg), .b_hi_gate(b_hg), .b_lo_gate(b_lg)
  );

  typedef struct { logic [3:0] v; string tag; } exp_t;
  exp_t sb_q[$];
  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;

  // reference model state: cycles since release (-1 = stopped)
  int mph = -1;
  bit mhi[2], mlo[2];
  int mhc[2], mlc[2];

  function automatic logic [3:0] outs();
    return {a_hg, a_lg, b_hg, b_lg};
  endfunction

  task automatic direct(input logic [3:0] e, input string tag);
    n_vec++;
    if (outs() !== e) begin
      n_bad++;
      $display("FAIL %s: gates {aH,aL,bH,bL} got %b expected %b", tag, outs(), e);
    end
  endtask

  // driver: predicts the outputs after the next edge, queues them, waits
  task automatic tick(input string tag);
    bit halt, en, run_pre, refr_pre, run_post, refr_post;
    logic [3:0] e;
    exp_t item;
    halt     = dis | uv;
    en       = (mph >= 0) && !halt;
    run_pre  = (mph >= UP);
    refr_pre = (mph >= 0) && (mph < RW);
    for (int c = 0; c < 2; c++) begin
      bit hreq, lreq, hw, lw, lo_pre;
      hreq   = (c == 0) ? a_hr : b_hr;
      lreq   = (c == 0) ? a_lr : b_lr;
      hw     = en && run_pre && hreq && !lreq;
      lw     = en && lreq;
      lo_pre = mlo[c] || refr_pre;
      if (!lw) begin
        mlo[c] = 1'b0; mlc[c] = 0;
      end else if (!mlo[c]) begin
        if (mhi[c]) mlc[c] = 0;
        else if (mlc[c] >= int'(lo_dly)) mlo[c] = 1'b1;
        else mlc[c]++;
      end
      if (!hw) begin
        mhi[c] = 1'b0; mhc[c] = 0;
      end else if (!mhi[c]) begin
        if (lo_pre) mhc[c] = 0;
        else if (mhc[c] >= int'(hi_dly)) mhi[c] = 1'b1;
        else mhc[c]++;
      end
    end
    if (halt) mph = -1;
    else if (mph < 0) mph = 0;
    else if (mph < 1000) mph++;
    run_post  = (mph >= UP);
    refr_post = (mph >= 0) && (mph < RW);
    e = {mhi[0] && run_post && !halt, (mlo[0] || refr_post) && !halt,
         mhi[1] && run_post && !halt, (mlo[1] || refr_post) && !halt};
    item.v = e;
    item.tag = tag;
    sb_q.push_back(item);
    @(negedge clk);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  // monitor: compares each queued prediction just after its edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        n_vec++;
        if (outs() !== it.v) begin
          n_bad++;
          $display("FAIL %s: gates {aH,aL,bH,bL} got %b expected %b at %0t",
                   it.tag, outs(), it.v, $time);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    a_hr = 1'b1; a_lr = 1'b1; b_hr = 1'b1; b_lr = 1'b0;
    repeat (3) @(negedge clk);
    direct(4'b0000, "R12 reset state");
    rst_n = 1'b1;
    // R1: stop held, requests active
    ticks(4, "R1");
    // R2: fault flag alone
    dis = 1'b0; uv = 1'b1;
    ticks(4, "R2");
    // R10/R11/R12: first release after reset and stop
    hi_dly = 8'd3; lo_dly = 8'd2;
    a_hr = 1'b1; a_lr = 1'b0; b_hr = 1'b0; b_lr = 1'b1;
    uv = 1'b0;
    ticks(RW, "R10");
    ticks(UP - RW + 8, "R11");
    // R4/R5/R6: leg A single-input mode
    ticks(8, "R5");
    a_lr = 1'b1; ticks(8, "R6");
    a_lr = 1'b0; ticks(8, "R5");
    a_lr = 1'b1; ticks(4, "R4");
    a_lr = 1'b0; ticks(7, "R4");
    // R3: both requests high on both legs
    a_hr = 1'b1; a_lr = 1'b1; b_hr = 1'b1; b_lr = 1'b1;
    ticks(8, "R3");
    // R7: zero settings, one dead cycle each way
    hi_dly = 8'd0; lo_dly = 8'd0; b_hr = 1'b0; b_lr = 1'b0;
    for (int k = 0; k < 4; k++) begin
      a_lr = ~a_lr; ticks(3, "R7");
    end
    // R8: drops during a pending delay
    hi_dly = 8'd6; lo_dly = 8'd5;
    a_hr = 1'b1; a_lr = 1'b1; ticks(8, "R8");
    a_lr = 1'b0; ticks(4, "R8");
    a_lr = 1'b1; ticks(3, "R8");
    a_lr = 1'b0; ticks(3, "R8");
    a_hr = 1'b0; ticks(2, "R8");
    a_hr = 1'b1; ticks(10, "R8");
    a_lr = 1'b1; ticks(3, "R8");
    a_lr = 1'b0; ticks(10, "R8");
    // R9: legs driven with different patterns
    hi_dly = 8'd2; lo_dly = 8'd4;
    b_hr = 1'b1; b_lr = 1'b1; a_lr = 1'b1;
    ticks(4, "R9");
    b_lr = 1'b0; ticks(3, "R9");
    a_lr = 1'b0; ticks(5, "R9");
    b_hr = 1'b0; b_lr = 1'b1; ticks(8, "R9");
    a_lr = 1'b1; ticks(8, "R9");
    // R1: immediate clear mid-run, then a second restart
    dis = 1'b1; #1;
    direct(4'b0000, "R1 same cycle");
    tick("R1");
    tick("R1");
    dis = 1'b0; b_hr = 1'b1; b_lr = 1'b1; a_lr = 1'b0;
    ticks(RW, "R10");
    ticks(UP - RW + 8, "R11");
    ticks(2, "R13");
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule